// File: doc/BRIEF.md
# UART with Fractional Baud Generator and Address Filtering

This block is a serial UART with a small register interface. Software loads a divisor and, when it wants a finer baud rate, a fractional setting made of an integer multiplier and an 11-bit fraction over 2048. A transmit holding register feeds a shifter. A receive holding register gives software each received byte, and a line status word reports the state of both paths. An interrupt line combines the receive-ready and transmit-empty events under separate enables.

On a multi-drop bus the block can run in network mode. Each character then carries a ninth bit that marks it as an address frame, and this bit sits where a parity bit would normally go. The node compares each address frame with its own 8-bit address and accepts only the data frames that follow a matching address.

Top module: `uart_fracnet`

## Requirements
- R1: After reset the serial output is high, the interrupt is low, the status word (offset 2) reads 0x0060, and the divisor (offset 4) reads 1.
- R2: A character is sent and received as one low start bit, then data bits LSB first, then one high stop bit. With the serial output looped back to the input, each byte written to the data register (offset 0) comes back in the receive holding register.
- R3: When control bit 0 (offset 3) is clear, one bit lasts 32×DL clock cycles, where DL is the divisor (a DL of 0 acts as 1). The M and N fields have no effect in this mode.
- R4: When control bit 0 is set, a bit lasts 16 sub-ticks. A sub-tick lasts 2×DL×(M + c) cycles, where c is the carry out of an 11-bit accumulator that adds N once per sub-tick. The average bit period is therefore 32×DL×(M+N/2048). The fraction register (offset 5) holds M in bits 12:11 and N in bits 10:0, and an M of 0 acts as 1.
- R5: Status bit 5 (transmit holding empty) clears on a write to the data register and sets when the shifter takes the byte. Status bit 6 is set only when the holding register is empty and the shifter is idle.
- R6: Status bit 0 (receive ready) sets when a character is stored and clears when the data register is read. If a character arrives while bit 0 is set, the new byte replaces the old one and status bit 1 (overrun) sets. Bit 1 clears when the status word is read.
- R7: Bit 7 of the interrupt enable register (offset 1) selects network mode. In network mode each frame has a ninth bit, which is taken from control bit 1 on transmit. A received frame whose ninth bit is 1 is an address frame and is never stored. It turns reception on if its byte equals the node address register (offset 6) and off otherwise. Data frames are stored only while reception is on.
- R8: The interrupt output equals (enable bit 0 AND receive ready) OR (enable bit 1 AND transmit holding empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reads of data and status have side effects) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach from the ports is the address filter in network mode. It depends on an earlier address frame, and a dropped frame leaves no trace on any output. The bench loops the serial output back to the input and sends address/data sequences with the ninth bit set and cleared: a mismatch, a match, a repeated data frame, then a mismatch again. After each step it reads receive-ready to confirm that the expected frames were dropped or stored. Fractional timing is observed by measuring the first low run of chosen bytes. With these settings, 16 sub-ticks always hold a whole number of accumulator carries, so each bit has an exact length.

// File: rtl/uart_fracnet_pkg.sv
package uart_fracnet_pkg;
    localparam int ADDR_W = 3;
    localparam int BUS_W  = 16;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_IEN  = 3'd1,
        REG_STAT = 3'd2,
        REG_CTRL = 3'd3,
        REG_DIV  = 3'd4,
        REG_FRAC = 3'd5,
        REG_NODE = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_st_e;

    localparam int IEN_NET_BIT = 7;
endpackage

// File: rtl/uart_fracnet_baud.sv
module uart_fracnet_baud #(
    parameter int DL_W = 16,
    parameter int M_W  = 2,
    parameter int N_W  = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DL_W-1:0] dl,
    input  logic            frac_en,
    input  logic [M_W-1:0]  m_fld,
    input  logic [N_W-1:0]  n_fld,
    output logic            tick
);
    localparam int PRE_W = DL_W + 1;
    localparam int UN_W  = M_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [UN_W-1:0]  units;
        logic [N_W-1:0]   acc;
        logic             tick;
    } st_t;

    st_t s_d, s_q;
    logic [DL_W-1:0]  dl_eff;
    logic [PRE_W-1:0] pre_lim;
    logic [N_W:0]     acc_sum;
    logic [UN_W-1:0]  m_eff, target;

    always_comb begin
        dl_eff  = (dl == '0) ? DL_W'(1) : dl;
        pre_lim = {dl_eff, 1'b0} - PRE_W'(1);
        acc_sum = {1'b0, s_q.acc} + {1'b0, n_fld};
        m_eff   = (m_fld == '0) ? UN_W'(1) : {1'b0, m_fld};
        target  = frac_en ? (m_eff + UN_W'(acc_sum[N_W])) : UN_W'(1);
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (s_q.pre >= pre_lim) begin
            s_d.pre = '0;
            if (s_q.units + UN_W'(1) >= target) begin
                s_d.units = '0;
                s_d.tick  = 1'b1;
                if (frac_en) s_d.acc = acc_sum[N_W-1:0];
            end else begin
                s_d.units = s_q.units + UN_W'(1);
            end
        end else begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    // Every sub-tick spans at least two clock cycles
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tick |=> !s_q.tick);
endmodule

// File: rtl/uart_fracnet_tx.sv
module uart_fracnet_tx
    import uart_fracnet_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        hold_full,
    input  logic [DW:0] hold_data,
    input  logic        nine,
    output logic        take,
    output logic        busy,
    output logic        txd
);
    localparam int CNT_W = $clog2(DW + 2);

    typedef struct packed {
        line_st_e         st;
        logic [3:0]       sub;
        logic [CNT_W-1:0] idx;
        logic [DW:0]      sh;
        logic             txd;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        last = nine ? CNT_W'(DW) : CNT_W'(DW - 1);
        if (tick) begin
            if (s_q.st == LN_IDLE) begin
                if (hold_full) begin
                    take      = 1'b1;
                    s_d.sh    = hold_data;
                    s_d.st    = LN_START;
                    s_d.sub   = '0;
                    s_d.txd   = 1'b0;
                end
            end else begin
                s_d.sub = s_q.sub + 4'd1;
                if (s_q.sub == 4'd15) begin
                    case (s_q.st)
                        LN_START: begin
                            s_d.st  = LN_DATA;
                            s_d.idx = '0;
                            s_d.txd = s_q.sh[0];
                        end
                        LN_DATA: begin
                            if (s_q.idx == last) begin
                                s_d.st  = LN_STOP;
                                s_d.txd = 1'b1;
                            end else begin
                                s_d.sh  = s_q.sh >> 1;
                                s_d.idx = s_q.idx + CNT_W'(1);
                                s_d.txd = s_q.sh[1];
                            end
                        end
                        default: s_d.st = LN_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= LN_IDLE;
            s_q.txd <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st != LN_IDLE);
    assign txd  = s_q.txd;

    // The line only changes on a sub-tick boundary
    assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.txd) |-> $past(tick));
endmodule

// File: rtl/uart_fracnet_rx.sv
module uart_fracnet_rx
    import uart_fracnet_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          nine,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          flag
);
    localparam int CNT_W = $clog2(DW + 2);

    typedef struct packed {
        line_st_e         st;
        logic [3:0]       sub;
        logic [CNT_W-1:0] idx;
        logic [DW:0]      sh;
        logic             s1;
        logic             s2;
        logic             valid;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        s_d       = s_q;
        s_d.s1    = rxd;
        s_d.s2    = s_q.s1;
        s_d.valid = 1'b0;
        last      = nine ? CNT_W'(DW) : CNT_W'(DW - 1);
        if (tick) begin
            s_d.sub = s_q.sub + 4'd1;
            case (s_q.st)
                LN_IDLE: begin
                    if (!s_q.s2) begin
                        s_d.st  = LN_START;
                        s_d.sub = '0;
                    end
                end
                LN_START: begin
                    if (s_q.sub == 4'd7) begin
                        s_d.st  = s_q.s2 ? LN_IDLE : LN_DATA;
                        s_d.sub = '0;
                        s_d.idx = '0;
                    end
                end
                LN_DATA: begin
                    if (s_q.sub == 4'd15) begin
                        s_d.sh = {s_q.s2, s_q.sh[DW:1]};
                        if (s_q.idx == last) s_d.st  = LN_STOP;
                        else                 s_d.idx = s_q.idx + CNT_W'(1);
                    end
                end
                default: begin
                    if (s_q.sub == 4'd15) begin
                        s_d.valid = 1'b1;
                        s_d.st    = LN_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= LN_IDLE;
            s_q.s1 <= 1'b1;
            s_q.s2 <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid = s_q.valid;
    assign data  = nine ? s_q.sh[DW-1:0] : s_q.sh[DW:1];
    assign flag  = nine & s_q.sh[DW];

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> !s_q.valid);
endmodule

// File: rtl/uart_fracnet.sv
module uart_fracnet
    import uart_fracnet_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DL_W = 16,
    parameter int M_W  = 2,
    parameter int N_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              txd,
    input  logic              rxd,
    output logic              irq
);
    typedef struct packed {
        logic [7:0]      ien;
        logic [1:0]      ctrl;
        logic [DL_W-1:0] dl;
        logic [M_W-1:0]  m;
        logic [N_W-1:0]  n;
        logic [DW-1:0]   node;
        logic [DW:0]     thr;
        logic            thr_full;
        logic [DW-1:0]   rbr;
        logic            ready;
        logic            ovr;
        logic            listen;
    } regs_t;

    regs_t r_d, r_q;
    logic tick, take, tx_busy, rx_valid, rx_flag, net;
    logic [DW-1:0] rx_data;
    logic rd_data, rd_stat;

    assign net     = r_q.ien[IEN_NET_BIT];
    assign rd_data = bus_rd && (bus_addr == REG_DATA);
    assign rd_stat = bus_rd && (bus_addr == REG_STAT);

    uart_fracnet_baud #(.DL_W(DL_W), .M_W(M_W), .N_W(N_W)) baud_i (
        .clk, .rst_n, .dl(r_q.dl), .frac_en(r_q.ctrl[0]),
        .m_fld(r_q.m), .n_fld(r_q.n), .tick(tick));

    uart_fracnet_tx #(.DW(DW)) tx_i (
        .clk, .rst_n, .tick, .hold_full(r_q.thr_full), .hold_data(r_q.thr),
        .nine(net), .take(take), .busy(tx_busy), .txd(txd));

    uart_fracnet_rx #(.DW(DW)) rx_i (
        .clk, .rst_n, .tick, .rxd, .nine(net),
        .valid(rx_valid), .data(rx_data), .flag(rx_flag));

    always_comb begin
        r_d = r_q;
        if (take) r_d.thr_full = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                REG_DATA: begin
                    r_d.thr      = {r_q.ctrl[1] & net, bus_wdata[DW-1:0]};
                    r_d.thr_full = 1'b1;
                end
                REG_IEN:  r_d.ien  = bus_wdata[7:0];
                REG_CTRL: r_d.ctrl = bus_wdata[1:0];
                REG_DIV:  r_d.dl   = bus_wdata[DL_W-1:0];
                REG_FRAC: {r_d.m, r_d.n} = bus_wdata[M_W+N_W-1:0];
                REG_NODE: r_d.node = bus_wdata[DW-1:0];
                default: ;
            endcase
        end
        if (rd_data) r_d.ready = 1'b0;
        if (rd_stat) r_d.ovr   = 1'b0;
        if (rx_valid) begin
            if (net && rx_flag) begin
                r_d.listen = (rx_data == r_q.node);
            end else if (!net || r_q.listen) begin
                r_d.rbr   = rx_data;
                r_d.ovr   = r_d.ovr | r_q.ready;
                r_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.dl <= DL_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            REG_DATA: bus_rdata = BUS_W'(r_q.rbr);
            REG_IEN:  bus_rdata = BUS_W'(r_q.ien);
            REG_STAT: bus_rdata = BUS_W'({!r_q.thr_full && !tx_busy, !r_q.thr_full,
                                          3'b000, r_q.ovr, r_q.ready});
            REG_CTRL: bus_rdata = BUS_W'(r_q.ctrl);
            REG_DIV:  bus_rdata = BUS_W'(r_q.dl);
            REG_FRAC: bus_rdata = BUS_W'({r_q.m, r_q.n});
            REG_NODE: bus_rdata = BUS_W'(r_q.node);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = (r_q.ien[0] & r_q.ready) | (r_q.ien[1] & !r_q.thr_full);

    assert_thr_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DATA) |=> r_q.thr_full);

    assert_take_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> r_q.thr_full);

    assert_ready_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_valid) |=> !r_q.ready);

    assert_drop_unaddressed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && net && !rx_flag && !r_q.listen && !rd_data)
        |=> ($stable(r_q.ready) && $stable(r_q.rbr)));
endmodule

// File: tb/uart_fracnet_tb_top.sv
module uart_fracnet_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        txd, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    uart_fracnet dut_i (
        .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .txd, .rxd(txd), .irq);

    typedef struct packed {
        logic        frac;
        logic [15:0] dl;
        logic [1:0]  m;
        logic [10:0] n;
        logic [7:0]  ch;
        logic [31:0] low;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd1, 2'd0, 11'd0,    8'h00, 32'd288},  // R3
        '{1'b0, 16'd2, 2'd0, 11'd0,    8'hF0, 32'd320},  // R3
        '{1'b0, 16'd1, 2'd3, 11'd2047, 8'h7F, 32'd32},   // R3 M,N ignored
        '{1'b1, 16'd1, 2'd1, 11'd1024, 8'h00, 32'd432},  // R4
        '{1'b1, 16'd1, 2'd2, 11'd0,    8'hF8, 32'd256},  // R4
        '{1'b1, 16'd1, 2'd1, 11'd512,  8'hFE, 32'd80},   // R4
        '{1'b1, 16'd1, 2'd0, 11'd0,    8'h00, 32'd288}   // R4 M=0 as 1
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        s = '0;
        while (!s[6]) rd(3'd2, s);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_net(input logic is_addr, input logic [7:0] b);
        wr(3'd3, {14'd0, is_addr, 1'b0});
        wr(3'd0, {8'd0, b});
        wait_cyc(500);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        int cnt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 txd", {31'd0, txd}, 32'd1);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(3'd2, r); chk("R1 status", {16'd0, r}, 32'h60);
        rd(3'd4, r); chk("R1 divisor", {16'd0, r}, 32'd1);

        // Table of baud settings and bytes, loopback (R2, R3, R4)
        for (int i = 0; i < NV; i++) begin
            wr(3'd4, VECS[i].dl);
            wr(3'd5, {3'd0, VECS[i].m, VECS[i].n});
            wr(3'd3, {15'd0, VECS[i].frac});
            wr(3'd0, {8'd0, VECS[i].ch});
            while (txd) @(negedge clk);
            cnt = 0;
            while (!txd) begin cnt++; @(negedge clk); end
            chk(VECS[i].frac ? "R4 low run" : "R3 low run", cnt, VECS[i].low);
            wait_idle();
            rd(3'd0, r);
            chk("R2 loopback byte", {16'd0, r}, {24'd0, VECS[i].ch});
        end

        // R5, R6, R8: back-to-back bytes, overrun
        wr(3'd4, 16'd1); wr(3'd3, 16'd0); wr(3'd1, 16'h0002);
        chk("R8 tx empty irq", {31'd0, irq}, 32'd1);
        wr(3'd0, 16'h00A5);
        wait_cyc(20);
        wr(3'd0, 16'h003C);
        rd(3'd2, r);
        chk("R5 holding full, not idle", {16'd0, r & 16'h0060}, 32'h0);
        chk("R8 irq low when holding full", {31'd0, irq}, 32'd0);
        wait_cyc(900);
        rd(3'd2, r); chk("R6 overrun status", {16'd0, r}, 32'h63);
        rd(3'd0, r); chk("R6 newer byte kept", {16'd0, r}, 32'h3C);
        rd(3'd2, r); chk("R6 flags cleared", {16'd0, r}, 32'h60);

        // R8 receive interrupt
        wr(3'd1, 16'h0001);
        wr(3'd0, 16'h0005);
        wait_cyc(500);
        chk("R8 rx irq", {31'd0, irq}, 32'd1);
        rd(3'd0, r);
        chk("R8 rx irq cleared", {31'd0, irq}, 32'd0);

        // R7 network mode address filtering
        wr(3'd1, 16'h0080); wr(3'd6, 16'h005A);
        send_net(1'b1, 8'h33); send_net(1'b0, 8'h11);
        rd(3'd2, r); chk("R7 drop after mismatch", {31'd0, r[0]}, 32'd0);
        send_net(1'b1, 8'h5A);
        rd(3'd2, r); chk("R7 address frame not stored", {31'd0, r[0]}, 32'd0);
        send_net(1'b0, 8'h22);
        rd(3'd2, r); chk("R7 ready after match", {31'd0, r[0]}, 32'd1);
        rd(3'd0, r); chk("R7 matched data", {16'd0, r}, 32'h22);
        send_net(1'b0, 8'h23);
        rd(3'd0, r); chk("R7 still listening", {16'd0, r}, 32'h23);
        send_net(1'b1, 8'h33); send_net(1'b0, 8'h44);
        rd(3'd2, r); chk("R7 drop after new mismatch", {31'd0, r[0]}, 32'd0);

        done = 1;
        summary();
        $finish;
    end
endmodule